// File: doc/BRIEF.md
# Out-of-Order Dispatch and Wakeup Engine for Add and Multiply

This block is a compact out-of-order execution core for register-to-register add and multiply operations. Each cycle it can take one decoded instruction, in program order. The instruction names a destination and two source registers. It goes into a station of the pool that belongs to its functional unit: one pool feeds a pipelined adder, the other feeds a pipelined multiplier.

A rename table holds one valid bit and one tag per architectural register. A source whose register is valid is copied by value. A source whose register is pending is copied by tag. That tag is later resolved by watching a single shared result bus.

Completed results are broadcast on that bus. Waiting stations capture them, and the register file and rename table are updated only when the broadcast tag is still the one the table expects. Within a pool, the oldest ready station issues first. A flush input discards all in-flight work and keeps the committed register values.

Top module: `ooo_dispatch_core`

## Requirements
- R1: After reset every register r holds the value r and is marked valid with tag 0. Both pools report free space, so `dispReady` is high for either unit, and the result bus is idle.
- R2: A dispatch is accepted in a cycle where `dispValid` and `dispReady` are both high. A valid source is copied by value. A pending source is copied by tag, unless the bus broadcasts that tag in the same cycle, in which case the bus value is taken. After acceptance the destination register reads back as pending, with tag {unit, station}: the top tag bit is 0 for the adder and 1 for the multiplier, and the low two bits are the station index. Sources are read before the destination is renamed.
- R3: A new instruction takes the lowest-numbered free station of its pool.
- R4: An instruction dispatched in cycle d with both operands valid is broadcast in cycle d+3 for an add and in cycle d+5 for a multiply. The result is the low 16 bits of the sum or of the product.
- R5: A station waiting on a tag captures the broadcast value at the end of the broadcast cycle b and issues in cycle b+1. A dependent add is therefore broadcast in cycle b+3.
- R6: When more than one station of a pool is ready, the one dispatched earliest issues first, whatever its station index.
- R7: A broadcast writes a register and sets its valid bit only when that register is pending on exactly the broadcast tag. The stored tag is never cleared. A stale broadcast leaves a newer value untouched.
- R8: A station is released in its broadcast cycle. While the target pool has no free station, `dispReady` is low and the instruction is held rather than accepted. The other pool is not affected.
- R9: If both units finish in the same cycle, the multiplier result goes on the bus. The adder result is held and broadcast in the following cycle.
- R10: A flush empties all stations, pipelines and the held result, so no pending result is ever broadcast. Every register is then marked valid with its committed value, and later dispatches work normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discards all in-flight state |
| dispValid | input | 1 | A decoded instruction is offered |
| dispIsMul | input | 1 | 1 = multiply, 0 = add |
| dispDst | input | 3 | Destination register |
| dispSrcA | input | 3 | First source register |
| dispSrcB | input | 3 | Second source register |
| dispReady | output | 1 | The target pool has a free station |
| cdbValid | output | 1 | Result bus carries a result |
| cdbTag | output | 3 | Tag of the broadcast result |
| cdbData | output | 16 | Broadcast result value |
| rdAddr | input | 3 | Register inspection address |
| rdValid | output | 1 | Valid bit of the inspected register |
| rdTag | output | 3 | Stored tag of the inspected register |
| rdData | output | 16 | Committed value of the inspected register |

## Verification
Isolated adds and multiplies are run through a chain of registers, which pins down the latency and the arithmetic of each unit on its own. A mixed burst then does three things at once: a multiply, a dependent add and an independent add finish so that the two units collide on the bus. That burst shows the bus priority, the one-cycle hold and the tag wakeup.

A second burst is built so that the older ready station has the higher index. An oldest-first choice and a lowest-index choice then broadcast in a different order, which tells them apart. Further sequences fill the multiplier pool to force a stall, let two writers of one register finish in reverse order, and flush in-flight work.

// File: rtl/ooo_pkg.sv
`timescale 1ns/1ps
package ooo_pkg;
  typedef enum logic [1:0] {BUS_NONE, BUS_MUL, BUS_HOLD, BUS_ADD} bus_src_e;

  typedef struct packed {
    bus_src_e busSel;
    logic     holdLoad;
    logic     allocAdd;
    logic     allocMul;
    logic     addAdvance;
  } ctrl_strobe_t;
endpackage

// File: rtl/ooo_rs_pool.sv
`timescale 1ns/1ps
module ooo_rs_pool #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 3,
  parameter int IDX_W  = 2,
  parameter int UNIT   = 0,
  localparam int TAG_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              alloc,
  input  logic              aValid,
  input  logic [TAG_W-1:0]  aTag,
  input  logic [DATA_W-1:0] aData,
  input  logic              bValid,
  input  logic [TAG_W-1:0]  bTag,
  input  logic [DATA_W-1:0] bData,
  input  logic              busValid,
  input  logic [TAG_W-1:0]  busTag,
  input  logic [DATA_W-1:0] busData,
  input  logic              issueEn,
  output logic              hasFree,
  output logic [IDX_W-1:0]  freeIdx,
  output logic              issueValid,
  output logic [DATA_W-1:0] issueA,
  output logic [DATA_W-1:0] issueB,
  output logic [TAG_W-1:0]  issueTag
);
  logic [DEPTH-1:0] busy, issued, vA, vB, ready, pickOh, freeing;
  logic [TAG_W-1:0]  tA [DEPTH];
  logic [TAG_W-1:0]  tB [DEPTH];
  logic [DATA_W-1:0] dA [DEPTH];
  logic [DATA_W-1:0] dB [DEPTH];
  logic [DEPTH-1:0]  older [DEPTH];  // older[i][j]: j was dispatched before i
  logic [IDX_W-1:0]  sel;

  always_comb begin
    hasFree = 1'b0;
    freeIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        hasFree = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ready[i]   = busy[i] && !issued[i] && vA[i] && vB[i];
      freeing[i] = busValid && (busTag == {1'(UNIT), IDX_W'(i)});
    end
    for (int i = 0; i < DEPTH; i++) begin
      pickOh[i] = ready[i];
      for (int j = 0; j < DEPTH; j++)
        if (ready[j] && older[i][j]) pickOh[i] = 1'b0;
    end
    sel = '0;
    for (int i = 0; i < DEPTH; i++)
      if (pickOh[i]) sel = IDX_W'(i);
    issueValid = |pickOh;
    issueA     = dA[sel];
    issueB     = dB[sel];
    issueTag   = {1'(UNIT), sel};
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst || flush) begin
        busy[i]   <= 1'b0;
        issued[i] <= 1'b0;
        older[i]  <= '0;
      end else begin
        if (freeing[i]) begin
          busy[i]   <= 1'b0;
          issued[i] <= 1'b0;
        end
        if (busy[i] && !vA[i] && busValid && tA[i] == busTag) begin
          vA[i] <= 1'b1;
          dA[i] <= busData;
        end
        if (busy[i] && !vB[i] && busValid && tB[i] == busTag) begin
          vB[i] <= 1'b1;
          dB[i] <= busData;
        end
        if (issueEn && issueValid && sel == IDX_W'(i)) issued[i] <= 1'b1;
        if (alloc && freeIdx == IDX_W'(i)) begin
          busy[i]   <= 1'b1;
          issued[i] <= 1'b0;
          vA[i] <= aValid; tA[i] <= aTag; dA[i] <= aData;
          vB[i] <= bValid; tB[i] <= bTag; dB[i] <= bData;
          older[i] <= busy & ~freeing;
        end else if (alloc) begin
          older[i][freeIdx] <= 1'b0;
        end
      end
    end
  end

  // R8
  alloc_needs_free_chk: assert property (@(posedge clk) disable iff (rst)
    alloc |-> hasFree);

  // R8
  bus_frees_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busValid && busTag[TAG_W-1] == 1'(UNIT)) |-> busy[busTag[IDX_W-1:0]]);
endmodule

// File: rtl/ooo_fu_pipe.sv
`timescale 1ns/1ps
module ooo_fu_pipe #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 3,
  parameter int LAT    = 2,
  parameter bit IS_MUL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              advance,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  input  logic [TAG_W-1:0]  inTag,
  output logic              outValid,
  output logic [TAG_W-1:0]  outTag,
  output logic [DATA_W-1:0] outData
);
  logic              stValid [LAT];
  logic [TAG_W-1:0]  stTag   [LAT];
  logic [DATA_W-1:0] stData  [LAT];
  logic [DATA_W-1:0] result;

  generate
    if (IS_MUL) begin : g_mul
      assign result = inA * inB;
    end else begin : g_add
      assign result = inA + inB;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int k = 0; k < LAT; k++) stValid[k] <= 1'b0;
    end else if (advance) begin
      stValid[0] <= inValid;
      stTag[0]   <= inTag;
      stData[0]  <= result;
      for (int k = 1; k < LAT; k++) begin
        stValid[k] <= stValid[k-1];
        stTag[k]   <= stTag[k-1];
        stData[k]  <= stData[k-1];
      end
    end
  end

  assign outValid = stValid[LAT-1];
  assign outTag   = stTag[LAT-1];
  assign outData  = stData[LAT-1];

  // R9
  frozen_output_chk: assert property (@(posedge clk) disable iff (rst || flush)
    (outValid && !advance) |=> (outValid && $stable(outTag) && $stable(outData)));
endmodule

// File: rtl/ooo_control.sv
`timescale 1ns/1ps
module ooo_control
  import ooo_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         dispValid,
  input  logic         dispIsMul,
  input  logic         addFree,
  input  logic         mulFree,
  input  logic         addDone,
  input  logic         mulDone,
  output logic         dispReady,
  output ctrl_strobe_t strobe
);
  logic holdFull;
  logic addStall;

  always_comb begin
    strobe   = '0;
    addStall = holdFull && mulDone && addDone;
    if (mulDone)       strobe.busSel = BUS_MUL;
    else if (holdFull) strobe.busSel = BUS_HOLD;
    else if (addDone)  strobe.busSel = BUS_ADD;
    else               strobe.busSel = BUS_NONE;
    strobe.addAdvance = !addStall;
    strobe.holdLoad   = addDone && !addStall && (strobe.busSel != BUS_ADD);
    dispReady         = dispIsMul ? mulFree : addFree;
    strobe.allocAdd   = dispValid && !dispIsMul && addFree && !flush;
    strobe.allocMul   = dispValid &&  dispIsMul && mulFree && !flush;
  end

  always_ff @(posedge clk) begin
    if (rst || flush)            holdFull <= 1'b0;
    else if (strobe.holdLoad)    holdFull <= 1'b1;
    else if (strobe.busSel == BUS_HOLD) holdFull <= 1'b0;
  end

  // R9
  hold_kept_chk: assert property (@(posedge clk) disable iff (rst || flush)
    (holdFull && mulDone) |=> holdFull);
endmodule

// File: rtl/ooo_datapath.sv
`timescale 1ns/1ps
module ooo_datapath
  import ooo_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 3,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  ctrl_strobe_t      strobe,
  input  logic [REG_W-1:0]  dispDst,
  input  logic [REG_W-1:0]  dispSrcA,
  input  logic [REG_W-1:0]  dispSrcB,
  input  logic [TAG_W-1:0]  allocTag,
  input  logic [TAG_W-1:0]  addOutTag,
  input  logic [DATA_W-1:0] addOutData,
  input  logic [TAG_W-1:0]  mulOutTag,
  input  logic [DATA_W-1:0] mulOutData,
  input  logic [REG_W-1:0]  rdAddr,
  output logic              srcAValid,
  output logic [TAG_W-1:0]  srcATag,
  output logic [DATA_W-1:0] srcAData,
  output logic              srcBValid,
  output logic [TAG_W-1:0]  srcBTag,
  output logic [DATA_W-1:0] srcBData,
  output logic              cdbValid,
  output logic [TAG_W-1:0]  cdbTag,
  output logic [DATA_W-1:0] cdbData,
  output logic              rdValid,
  output logic [TAG_W-1:0]  rdTag,
  output logic [DATA_W-1:0] rdData
);
  logic [NUM_REGS-1:0] ratValid;
  logic [TAG_W-1:0]    ratTag [NUM_REGS];
  logic [DATA_W-1:0]   regVal [NUM_REGS];
  logic [TAG_W-1:0]    holdTag;
  logic [DATA_W-1:0]   holdData;
  logic                renaming;

  assign renaming = strobe.allocAdd || strobe.allocMul;

  always_comb begin
    cdbValid = 1'b1;
    cdbTag   = '0;
    cdbData  = '0;
    case (strobe.busSel)
      BUS_MUL:  begin cdbTag = mulOutTag; cdbData = mulOutData; end
      BUS_HOLD: begin cdbTag = holdTag;   cdbData = holdData;   end
      BUS_ADD:  begin cdbTag = addOutTag; cdbData = addOutData; end
      default:  cdbValid = 1'b0;
    endcase
  end

  always_comb begin
    srcATag   = ratTag[dispSrcA];
    srcAValid = ratValid[dispSrcA] || (cdbValid && cdbTag == srcATag);
    srcAData  = ratValid[dispSrcA] ? regVal[dispSrcA] : cdbData;
    srcBTag   = ratTag[dispSrcB];
    srcBValid = ratValid[dispSrcB] || (cdbValid && cdbTag == srcBTag);
    srcBData  = ratValid[dispSrcB] ? regVal[dispSrcB] : cdbData;
  end

  assign rdValid = ratValid[rdAddr];
  assign rdTag   = ratTag[rdAddr];
  assign rdData  = regVal[rdAddr];

  always_ff @(posedge clk) begin
    if (strobe.holdLoad) begin
      holdTag  <= addOutTag;
      holdData <= addOutData;
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NUM_REGS; r++) begin
      if (rst) begin
        ratValid[r] <= 1'b1;
        ratTag[r]   <= '0;
        regVal[r]   <= DATA_W'(r);
      end else if (flush) begin
        ratValid[r] <= 1'b1;
      end else begin
        if (cdbValid && !ratValid[r] && ratTag[r] == cdbTag) begin
          regVal[r]   <= cdbData;
          ratValid[r] <= 1'b1;
        end
        if (renaming && dispDst == REG_W'(r)) begin
          ratValid[r] <= 1'b0;
          ratTag[r]   <= allocTag;
        end
      end
    end
  end

  // R2
  rename_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (renaming && !flush) |=> (!ratValid[$past(dispDst)] && ratTag[$past(dispDst)] == $past(allocTag)));

  // R7
  wake_matching_chk: assert property (@(posedge clk) disable iff (rst)
    (cdbValid && !flush && !ratValid[dispSrcA] && ratTag[dispSrcA] == cdbTag
     && !(renaming && dispDst == dispSrcA))
    |=> (ratValid[$past(dispSrcA)] && regVal[$past(dispSrcA)] == $past(cdbData)));
endmodule

// File: rtl/ooo_dispatch_core.sv
`timescale 1ns/1ps
module ooo_dispatch_core
  import ooo_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int STATIONS = 3,
  parameter int ADD_LAT  = 2,
  parameter int MUL_LAT  = 4,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int IDX_W   = (STATIONS > 1) ? $clog2(STATIONS) : 1,
  localparam int TAG_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              dispValid,
  input  logic              dispIsMul,
  input  logic [REG_W-1:0]  dispDst,
  input  logic [REG_W-1:0]  dispSrcA,
  input  logic [REG_W-1:0]  dispSrcB,
  output logic              dispReady,
  output logic              cdbValid,
  output logic [TAG_W-1:0]  cdbTag,
  output logic [DATA_W-1:0] cdbData,
  input  logic [REG_W-1:0]  rdAddr,
  output logic              rdValid,
  output logic [TAG_W-1:0]  rdTag,
  output logic [DATA_W-1:0] rdData
);
  ctrl_strobe_t strobe;
  logic              poolFree [2];
  logic [IDX_W-1:0]  poolIdx  [2];
  logic              issValid [2];
  logic [DATA_W-1:0] issA     [2];
  logic [DATA_W-1:0] issB     [2];
  logic [TAG_W-1:0]  issTag   [2];
  logic              outValid [2];
  logic [TAG_W-1:0]  outTag   [2];
  logic [DATA_W-1:0] outData  [2];
  logic              srcAValid, srcBValid;
  logic [TAG_W-1:0]  srcATag, srcBTag, allocTag;
  logic [DATA_W-1:0] srcAData, srcBData;

  assign allocTag = dispIsMul ? {1'b1, poolIdx[1]} : {1'b0, poolIdx[0]};

  ooo_control u_control (
    .clk, .rst, .flush, .dispValid, .dispIsMul,
    .addFree(poolFree[0]), .mulFree(poolFree[1]),
    .addDone(outValid[0]), .mulDone(outValid[1]),
    .dispReady, .strobe
  );

  ooo_datapath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_datapath (
    .clk, .rst, .flush, .strobe, .dispDst, .dispSrcA, .dispSrcB, .allocTag,
    .addOutTag(outTag[0]), .addOutData(outData[0]),
    .mulOutTag(outTag[1]), .mulOutData(outData[1]), .rdAddr,
    .srcAValid, .srcATag, .srcAData, .srcBValid, .srcBTag, .srcBData,
    .cdbValid, .cdbTag, .cdbData, .rdValid, .rdTag, .rdData
  );

  generate
    for (genvar g = 0; g < 2; g++) begin : g_unit
      logic advance;
      assign advance = (g == 1) ? 1'b1 : strobe.addAdvance;

      ooo_rs_pool #(.DATA_W(DATA_W), .DEPTH(STATIONS), .IDX_W(IDX_W), .UNIT(g)) u_pool (
        .clk, .rst, .flush,
        .alloc((g == 1) ? strobe.allocMul : strobe.allocAdd),
        .aValid(srcAValid), .aTag(srcATag), .aData(srcAData),
        .bValid(srcBValid), .bTag(srcBTag), .bData(srcBData),
        .busValid(cdbValid), .busTag(cdbTag), .busData(cdbData),
        .issueEn(advance), .hasFree(poolFree[g]), .freeIdx(poolIdx[g]),
        .issueValid(issValid[g]), .issueA(issA[g]), .issueB(issB[g]), .issueTag(issTag[g])
      );

      ooo_fu_pipe #(.DATA_W(DATA_W), .TAG_W(TAG_W),
                    .LAT((g == 1) ? MUL_LAT : ADD_LAT), .IS_MUL(g == 1)) u_pipe (
        .clk, .rst, .flush, .advance,
        .inValid(issValid[g]), .inA(issA[g]), .inB(issB[g]), .inTag(issTag[g]),
        .outValid(outValid[g]), .outTag(outTag[g]), .outData(outData[g])
      );
    end
  endgenerate
endmodule

// File: tb/ooo_dispatch_core_bench.sv
`timescale 1ns/1ps
module ooo_dispatch_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        dispValid = 1'b0;
  logic        dispIsMul = 1'b0;
  logic [2:0]  dispDst = '0, dispSrcA = '0, dispSrcB = '0, rdAddr = '0;
  logic        dispReady, cdbValid, rdValid;
  logic [2:0]  cdbTag, rdTag;
  logic [15:0] cdbData, rdData;
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ooo_dispatch_core u_ooo_dispatch_core (
    .clk, .rst, .flush, .dispValid, .dispIsMul, .dispDst, .dispSrcA, .dispSrcB,
    .dispReady, .cdbValid, .cdbTag, .cdbData, .rdAddr, .rdValid, .rdTag, .rdData
  );

  // {isMul, dst, srcA, srcB, expected result}; each runs alone into empty pools
  localparam logic [25:0] VECS [6] = '{
    {1'b0, 3'd1, 3'd2, 3'd3, 16'd5},
    {1'b1, 3'd4, 3'd1, 3'd3, 16'd15},
    {1'b0, 3'd0, 3'd4, 3'd4, 16'd30},
    {1'b1, 3'd5, 3'd0, 3'd4, 16'd450},
    {1'b0, 3'd6, 3'd5, 3'd7, 16'd457},
    {1'b1, 3'd7, 3'd6, 3'd6, 16'd12241}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic busChk(input string req, input logic v, input logic [2:0] t, input logic [15:0] d);
    chk({req, " bus valid"}, 32'(cdbValid), 32'(v));
    if (v) begin
      chk({req, " bus tag"}, 32'(cdbTag), 32'(t));
      chk({req, " bus data"}, 32'(cdbData), 32'(d));
    end
  endtask

  task automatic regChk(input string req, input logic [2:0] r, input logic v,
                        input logic [2:0] t, input logic [15:0] d);
    rdAddr = r;
    #0.5;
    chk({req, " reg valid"}, 32'(rdValid), 32'(v));
    chk({req, " reg tag"}, 32'(rdTag), 32'(t));
    chk({req, " reg data"}, 32'(rdData), 32'(d));
  endtask

  task automatic drive(input logic m, input logic [2:0] d, input logic [2:0] a, input logic [2:0] b);
    dispValid = 1'b1; dispIsMul = m; dispDst = d; dispSrcA = a; dispSrcB = b;
  endtask

  task automatic idle();
    dispValid = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    dispIsMul = 1'b0; #0.5; chk("R1 add ready", 32'(dispReady), 1);
    dispIsMul = 1'b1; #0.5; chk("R1 mul ready", 32'(dispReady), 1);
    busChk("R1", 1'b0, 3'd0, 16'd0);
    regChk("R1", 3'd3, 1'b1, 3'd0, 16'd3);

    // R4 table of isolated operations
    for (int i = 0; i < 6; i++) begin
      automatic logic [25:0] v = VECS[i];
      automatic int lat = v[25] ? 5 : 3;
      step(1);
      drive(v[25], v[24:22], v[21:19], v[18:16]);
      step(1);
      idle();
      step(lat - 2);
      busChk("R4 early", 1'b0, 3'd0, 16'd0);
      step(1);
      busChk("R4 result", 1'b1, {v[25], 2'b00}, v[15:0]);
      step(1);
      regChk("R4 writeback", v[24:22], 1'b1, {v[25], 2'b00}, v[15:0]);
    end

    // R2 rename and R7 stale tag: add r2 <- r1,r1 (5+5)
    step(1); drive(1'b0, 3'd2, 3'd1, 3'd1);
    step(1); idle();
    regChk("R2 pending", 3'd2, 1'b0, 3'd0, 16'd2);
    step(2); busChk("R4 add", 1'b1, 3'd0, 16'd10);
    step(1); regChk("R7 tag kept", 3'd2, 1'b1, 3'd0, 16'd10);

    // R3/R5/R9 mixed burst
    step(1); drive(1'b1, 3'd3, 3'd1, 3'd1);   // t0 mul 25
    step(1); drive(1'b0, 3'd4, 3'd3, 3'd1);   // t1 add dep -> 30
    step(1); drive(1'b0, 3'd5, 3'd1, 3'd1);   // t2 add 10
    step(1); idle();
    regChk("R3 second station", 3'd5, 1'b0, 3'd1, 16'd450);
    step(2); busChk("R9 mul wins", 1'b1, 3'd4, 16'd25);
    step(1); busChk("R9 held add", 1'b1, 3'd1, 16'd10);
    step(1); busChk("R5 gap", 1'b0, 3'd0, 16'd0);
    step(1); busChk("R5 dependent", 1'b1, 3'd0, 16'd30);
    step(1); regChk("R5 writeback", 3'd4, 1'b1, 3'd0, 16'd30);

    // R6 oldest first, with R2 same-cycle bypass
    step(1); drive(1'b1, 3'd6, 3'd1, 3'd1);   // t0 mul 25
    step(1); drive(1'b0, 3'd7, 3'd1, 3'd1);   // t1 add 10, station 0
    step(1); drive(1'b0, 3'd0, 3'd6, 3'd1);   // t2 add 30, station 1
    step(1); idle();
    step(1); busChk("R6 first add", 1'b1, 3'd0, 16'd10);
    step(1); busChk("R6 mul", 1'b1, 3'd4, 16'd25);
    drive(1'b0, 3'd2, 3'd6, 3'd6);            // t5 add 50, station 0, bypass
    step(1); idle();
    step(1); busChk("R6 not yet", 1'b0, 3'd0, 16'd0);
    step(1); busChk("R6 older station 1", 1'b1, 3'd1, 16'd30);
    step(1); busChk("R2 bypass younger", 1'b1, 3'd0, 16'd50);

    // R8 multiplier pool full
    step(1); drive(1'b1, 3'd5, 3'd1, 3'd1);   // 25 tag 4
    step(1); drive(1'b1, 3'd6, 3'd1, 3'd2);   // 250 tag 5
    step(1); drive(1'b1, 3'd7, 3'd2, 3'd2);   // 2500 tag 6
    step(1);
    idle(); dispIsMul = 1'b0; #0.5;
    chk("R8 adder pool unaffected", 32'(dispReady), 1);
    drive(1'b1, 3'd0, 3'd1, 3'd3);            // 125, held
    #0.5; chk("R8 stall", 32'(dispReady), 0);
    step(1); chk("R8 still stalled", 32'(dispReady), 0);
    step(1); busChk("R8 first mul", 1'b1, 3'd4, 16'd25);
    chk("R8 still stalled at release", 32'(dispReady), 0);
    step(1); busChk("R8 second mul", 1'b1, 3'd5, 16'd250);
    chk("R8 ready after release", 32'(dispReady), 1);
    step(1); idle(); busChk("R8 third mul", 1'b1, 3'd6, 16'd2500);
    step(3); busChk("R8 held not early", 1'b0, 3'd0, 16'd0);
    step(1); busChk("R8 held accepted", 1'b1, 3'd4, 16'd125);

    // R7 older writer finishes last
    step(1); drive(1'b1, 3'd5, 3'd1, 3'd3);   // 125 tag 4
    step(1); drive(1'b0, 3'd5, 3'd1, 3'd2);   // 55 tag 0
    step(1); idle();
    step(2); busChk("R7 young add", 1'b1, 3'd0, 16'd55);
    step(1); busChk("R7 old mul", 1'b1, 3'd4, 16'd125);
    step(1); regChk("R7 stale ignored", 3'd5, 1'b1, 3'd0, 16'd55);

    // R10 flush
    step(1); drive(1'b0, 3'd3, 3'd1, 3'd1);
    step(1); idle(); flush = 1'b1;
    step(1); flush = 1'b0;
    regChk("R10 committed kept", 3'd3, 1'b1, 3'd0, 16'd25);
    dispIsMul = 1'b0; #0.5; chk("R10 add ready", 32'(dispReady), 1);
    step(1); busChk("R10 no broadcast", 1'b0, 3'd0, 16'd0);
    step(1); busChk("R10 still quiet", 1'b0, 3'd0, 16'd0);
    drive(1'b0, 3'd3, 3'd1, 3'd2);            // 5+50
    step(1); idle();
    step(2); busChk("R10 after flush", 1'b1, 3'd0, 16'd55);
    step(1); regChk("R10 after flush", 3'd3, 1'b1, 3'd0, 16'd55);

    summary();
  end
endmodule